// File: doc/BRIEF.md
# GPIO Input Conditioning and Interrupt Detector

This block takes a word of asynchronous general-purpose input pins and turns it into a clean, clock-aligned value. Each pin can pass through a two-flop synchronizer, which a build-time switch inserts or removes. Each pin also has its own stability filter, enabled per pin. The conditioned word is presented as a read-only input value.

The same conditioned value drives interrupt detection. Every pin can watch for a rising edge, a falling edge, a high level and a low level. Each condition has its own per-pin enable, and all of them act only while the pin's interrupt enable is set. A detected event sets a sticky per-pin state bit. Software clears a state bit by writing a 1 to it. The interrupt line of each pin is its state bit gated by its interrupt enable. All configuration arrives as plain register values from a register block outside this one.

Top module: `pinmon_top`

## Requirements
- R1: `in_data_o` shows the conditioned value of every pin. With the filter of a pin off, that value is the synchronized pin.
- R2: With `SYNC_ON` = 1 (default), a pin change reaches `in_data_o` after exactly two rising clock edges. After the first edge the old value is still shown. With `SYNC_ON` = 0 the pin is used without flops.
- R3: When `filt_en_i[i]` = 1, bit i of `in_data_o` takes a new level only after the synchronized pin has held that level for `FILT_CYCLES` (16) consecutive samples. A shorter pulse never appears and never raises an event. When `filt_en_i[i]` = 0 the filter is bypassed.
- R4: A 0-to-1 change of conditioned bit i with `rise_en_i[i]` = 1 sets `irq_state_o[i]` on the following edge.
- R5: A 1-to-0 change of conditioned bit i with `fall_en_i[i]` = 1 sets `irq_state_o[i]`. A rising change does not set it when only the falling enable is on.
- R6: A conditioned bit that is 1 with `high_en_i[i]` = 1, or 0 with `low_en_i[i]` = 1, sets `irq_state_o[i]` on every cycle the level lasts.
- R7: No detection condition sets `irq_state_o[i]` while `irq_en_i[i]` = 0.
- R8: State bits are sticky. A cycle with `clr_we_i` = 1 clears each state bit whose `clr_data_i` bit is 1. If a condition is still present in that cycle, the set wins and the bit stays 1.
- R9: `irq_o[i]` is 1 exactly when `irq_state_o[i]` and `irq_en_i[i]` are both 1.
- R10: After reset, `in_data_o`, `irq_state_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PINS | Raw asynchronous pin values |
| filt_en_i | input | NUM_PINS | Per-pin stability filter enable |
| irq_en_i | input | NUM_PINS | Per-pin interrupt enable |
| rise_en_i | input | NUM_PINS | Rising-edge detection enable |
| fall_en_i | input | NUM_PINS | Falling-edge detection enable |
| high_en_i | input | NUM_PINS | High-level detection enable |
| low_en_i | input | NUM_PINS | Low-level detection enable |
| clr_we_i | input | 1 | Write strobe for clearing state bits |
| clr_data_i | input | NUM_PINS | Write-1-to-clear mask for state bits |
| in_data_o | output | NUM_PINS | Conditioned input value |
| irq_state_o | output | NUM_PINS | Sticky interrupt state bits |
| irq_o | output | NUM_PINS | Interrupt lines, state gated by enable |

## Verification
A wrong edge history register would show as a spurious or missing state bit on `irq_state_o` one edge after the conditioned value moves. A wrong filter counter shows two ways on `in_data_o`. Either a 15-sample glitch leaks through, or a held level never lands within about twenty cycles. Errors in sticky-bit or clear handling show on the edge right after the clear strobe, as a bit that survives a clear with no live condition or drops while one is present.

// File: rtl/pinmon_pkg.sv
// Shared types for the pin monitor: detection condition kinds.
package pinmon_pkg;
    typedef enum logic [1:0] {
        EV_RISE = 2'd0,
        EV_FALL = 2'd1,
        EV_HIGH = 2'd2,
        EV_LOW  = 2'd3
    } ev_kind_e;

    localparam int unsigned EV_KINDS = 4;
endpackage

// File: rtl/pinmon_sync.sv
// Input synchronizer for a word of pins.
// Assumes: SYNC_ON=1 inserts two flops per pin; SYNC_ON=0 passes pins straight through.
module pinmon_sync #(
    parameter int unsigned NUM_PINS = 32,
    parameter bit          SYNC_ON  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] d_i,
    output logic [NUM_PINS-1:0] q_o
);
    generate
        if (SYNC_ON) begin : g_sync
            logic [NUM_PINS-1:0] meta_q, stab_q;
            // Two-stage capture of the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= '0;
                    stab_q <= '0;
                end else begin
                    meta_q <= d_i;
                    stab_q <= meta_q;
                end
            end
            assign q_o = stab_q;
        end else begin : g_direct
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/pinmon_filter.sv
// Per-pin stability filter.
// Assumes: CYCLES >= 2. The held value moves only after the input has shown
// the same level for CYCLES consecutive samples. When en_i is 0 the raw input
// is passed through.
module pinmon_filter #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic raw_i,
    output logic val_o
);
    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] CNT_MAX  = CW'(CYCLES - 1);
    localparam logic [CW-1:0] CNT_ARM  = CW'(CYCLES - 2);

    logic          prev_q, held_q;
    logic [CW-1:0] cnt_q;

    // Count consecutive equal samples and commit the level once stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= raw_i;
            if (raw_i != prev_q) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if ((raw_i == prev_q) && (cnt_q >= CNT_ARM)) begin
                held_q <= prev_q;
            end
        end
    end

    // Select filtered or bypassed value.
    assign val_o = en_i ? held_q : raw_i;
endmodule

// File: rtl/pinmon_detect.sv
// Four-way condition detector with sticky write-1-to-clear state bits.
// Assumes: val_i is already clock-aligned. Edges are taken against the
// previous cycle's value. A set in the same cycle as a clear wins.
module pinmon_detect
    import pinmon_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] val_i,
    input  logic [NUM_PINS-1:0] irq_en_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    input  logic [NUM_PINS-1:0] high_en_i,
    input  logic [NUM_PINS-1:0] low_en_i,
    input  logic                clr_we_i,
    input  logic [NUM_PINS-1:0] clr_data_i,
    output logic [NUM_PINS-1:0] state_o
);
    logic [NUM_PINS-1:0] last_q, state_q, hit, clr_mask;
    logic [EV_KINDS-1:0][NUM_PINS-1:0] cond, cond_en;

    // Condition vectors and their enables, indexed by kind.
    always_comb begin
        cond[EV_RISE]    = val_i & ~last_q;
        cond[EV_FALL]    = ~val_i & last_q;
        cond[EV_HIGH]    = val_i;
        cond[EV_LOW]     = ~val_i;
        cond_en[EV_RISE] = rise_en_i;
        cond_en[EV_FALL] = fall_en_i;
        cond_en[EV_HIGH] = high_en_i;
        cond_en[EV_LOW]  = low_en_i;
    end

    // Merge the enabled conditions and gate them with the interrupt enable.
    always_comb begin
        hit = '0;
        for (int k = 0; k < EV_KINDS; k++) begin
            hit = hit | (cond[k] & cond_en[k]);
        end
        hit      = hit & irq_en_i;
        clr_mask = clr_we_i ? clr_data_i : '0;
    end

    // Keep edge history and the sticky state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            state_q <= '0;
        end else begin
            last_q  <= val_i;
            state_q <= (state_q & ~clr_mask) | hit;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/pinmon_top.sv
// Pin monitor top: synchronizer, per-pin filters, condition detector.
// Assumes: configuration inputs are held stable by an external register block.
module pinmon_top #(
    parameter int unsigned NUM_PINS    = 32,
    parameter bit          SYNC_ON     = 1'b1,
    parameter int unsigned FILT_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [NUM_PINS-1:0] filt_en_i,
    input  logic [NUM_PINS-1:0] irq_en_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    input  logic [NUM_PINS-1:0] high_en_i,
    input  logic [NUM_PINS-1:0] low_en_i,
    input  logic                clr_we_i,
    input  logic [NUM_PINS-1:0] clr_data_i,
    output logic [NUM_PINS-1:0] in_data_o,
    output logic [NUM_PINS-1:0] irq_state_o,
    output logic [NUM_PINS-1:0] irq_o
);
    logic [NUM_PINS-1:0] synced, conditioned;

    pinmon_sync #(.NUM_PINS(NUM_PINS), .SYNC_ON(SYNC_ON)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (synced)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_filt
            pinmon_filter #(.CYCLES(FILT_CYCLES)) filt_i (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (filt_en_i[i]),
                .raw_i (synced[i]),
                .val_o (conditioned[i])
            );
        end
    endgenerate

    pinmon_detect #(.NUM_PINS(NUM_PINS)) det_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .val_i      (conditioned),
        .irq_en_i   (irq_en_i),
        .rise_en_i  (rise_en_i),
        .fall_en_i  (fall_en_i),
        .high_en_i  (high_en_i),
        .low_en_i   (low_en_i),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .state_o    (irq_state_o)
    );

    // Interrupt lines follow the state bits only where enabled.
    assign in_data_o = conditioned;
    assign irq_o     = irq_state_o & irq_en_i;
endmodule

// File: rtl/pinmon_chk.sv
// Port-level property checker for pinmon_top, attached by bind.
module pinmon_chk #(
    parameter int unsigned NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] irq_en_i,
    input logic [NUM_PINS-1:0] rise_en_i,
    input logic [NUM_PINS-1:0] high_en_i,
    input logic                clr_we_i,
    input logic [NUM_PINS-1:0] clr_data_i,
    input logic [NUM_PINS-1:0] in_data_o,
    input logic [NUM_PINS-1:0] irq_state_o,
    input logic [NUM_PINS-1:0] irq_o
);
    // R8: a state bit only drops when a clear write named it.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_state_o) & ~($past(clr_we_i) ? $past(clr_data_i) : '0)
          & ~irq_state_o) == '0));

    // R7: newly set bits had their interrupt enable on.
    p_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_state_o & ~$past(irq_state_o) & ~$past(irq_en_i)) == '0));

    // R4: an observed rise with rise detection enabled sets the state bit.
    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(in_data_o) & ~$past(in_data_o, 2)
          & $past(irq_en_i & rise_en_i) & ~irq_state_o) == '0));

    // R6: a high level with high detection enabled keeps the state bit set.
    p_level_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(in_data_o & irq_en_i & high_en_i) & ~irq_state_o) == '0));

    // R9: an interrupt line needs both its state bit and its enable.
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((irq_o & ~irq_state_o) | (irq_o & ~irq_en_i)) == '0));
endmodule

bind pinmon_top pinmon_chk #(.NUM_PINS(NUM_PINS)) chk_i (.*);

// File: tb/pinmon_top_tb_top.sv
module pinmon_top_tb_top;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0, filt_en = '0, irq_en = '0, rise_en = '0;
    logic [N-1:0] fall_en = '0, high_en = '0, low_en = '0, clr_data = '0;
    logic         clr_we = 1'b0;
    logic [N-1:0] in_data, irq_state, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 in_data, 1 irq_state, 2 irq
        logic [N-1:0] mask;
        logic [N-1:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pinmon_top dut_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .filt_en_i(filt_en),
        .irq_en_i(irq_en), .rise_en_i(rise_en), .fall_en_i(fall_en),
        .high_en_i(high_en), .low_en_i(low_en), .clr_we_i(clr_we),
        .clr_data_i(clr_data), .in_data_o(in_data), .irq_state_o(irq_state),
        .irq_o(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_port(input int kind, input logic [N-1:0] mask,
                               input logic [N-1:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.mask = mask; it.exp = exp & mask; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic clear(input logic [N-1:0] m);
        clr_data = m; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0; clr_data = '0;
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [N-1:0] got;
                it = sb_q.pop_front();
                case (it.kind)
                    0: got = in_data;
                    1: got = irq_state;
                    default: got = irq;
                endcase
                got = got & it.mask;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, got, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_port(0, '1, '0, "R10 in_data reset");
        expect_port(1, '1, '0, "R10 state reset");
        expect_port(2, '1, '0, "R10 irq reset");

        // R1 / R2: bypassed pins, two-edge latency.
        pins = 32'hA5A5_0F0F; tick(3);
        expect_port(0, '1, 32'hA5A5_0F0F, "R1 pattern A");
        expect_port(1, '1, '0, "R7 no enables no state");
        pins = 32'h1234_5678; tick(1);
        expect_port(0, '1, 32'hA5A5_0F0F, "R2 old after one edge");
        tick(1);
        expect_port(0, '1, 32'h1234_5678, "R2 new after two edges");
        pins = '0; tick(3);
        expect_port(0, '1, '0, "R1 all zero");

        // R4: rising edge on pin 3, sticky after fall.
        irq_en[3] = 1'b1; rise_en[3] = 1'b1; tick(1);
        pins[3] = 1'b1; tick(3);
        expect_port(1, 32'h8, 32'h8, "R4 rise sets state");
        expect_port(2, 32'h8, 32'h8, "R9 irq follows state");
        pins[3] = 1'b0; tick(3);
        expect_port(1, 32'h8, 32'h8, "R8 sticky after fall");
        clear(32'h8);
        expect_port(1, '1, '0, "R8 w1c clears");

        // R5: falling edge on pin 5.
        irq_en[5] = 1'b1; fall_en[5] = 1'b1; tick(1);
        pins[5] = 1'b1; tick(3);
        expect_port(1, 32'h20, 32'h0, "R5 rise ignored by fall enable");
        pins[5] = 1'b0; tick(3);
        expect_port(1, 32'h20, 32'h20, "R5 fall sets state");
        expect_port(2, 32'h20, 32'h20, "R5 irq on fall");
        clear(32'h20);
        expect_port(1, '1, '0, "R8 clear pin 5");

        // R6: level high on pin 7 re-sets through a clear.
        irq_en[7] = 1'b1; high_en[7] = 1'b1; tick(1);
        pins[7] = 1'b1; tick(3);
        expect_port(1, 32'h80, 32'h80, "R6 level high sets");
        clear(32'h80);
        expect_port(1, 32'h80, 32'h80, "R6 R8 set wins over clear");
        pins[7] = 1'b0; tick(3);
        clear(32'h80);
        expect_port(1, 32'h80, 32'h0, "R6 cleared after level gone");

        // R6: level low on pin 9 (pin is already 0).
        irq_en[9] = 1'b1; low_en[9] = 1'b1; tick(3);
        expect_port(1, 32'h200, 32'h200, "R6 level low sets");
        pins[9] = 1'b1; tick(3);
        clear(32'h200);
        expect_port(1, 32'h200, 32'h0, "R6 low cleared after high");

        // R7: rise enable without interrupt enable on pin 12.
        rise_en[12] = 1'b1; tick(1);
        pins[12] = 1'b1; tick(3);
        expect_port(1, 32'h1000, 32'h0, "R7 no set without enable");

        // R9: state held but line masked when enable drops.
        pins[3] = 1'b1; tick(3);
        expect_port(1, 32'h8, 32'h8, "R4 second rise");
        irq_en[3] = 1'b0; tick(1);
        expect_port(1, 32'h8, 32'h8, "R9 state kept");
        expect_port(2, 32'h8, 32'h0, "R9 irq masked");

        // R3: filter on pin 10 drops a 15-sample pulse, passes a long hold.
        filt_en[10] = 1'b1; irq_en[10] = 1'b1; rise_en[10] = 1'b1; tick(1);
        pins[10] = 1'b1; tick(15);
        pins[10] = 1'b0; tick(20);
        expect_port(0, 32'h400, 32'h0, "R3 short pulse dropped");
        expect_port(1, 32'h400, 32'h0, "R3 no event from glitch");
        pins[10] = 1'b1; tick(25);
        expect_port(0, 32'h400, 32'h400, "R3 held level passes");
        expect_port(1, 32'h400, 32'h400, "R3 R4 filtered rise sets");

        tick(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule